// File: doc/BRIEF.md
# Control Store Access Sequencer

This block sequences microcode-directed accesses to a writable control store and to a fixed control ROM. A microinstruction raises a read or a write strobe. The block then takes the control-store address from a 16-bit address word held in a temporary register. For a write, it commits a 32-bit word formed from two 16-bit sources. For a read, it returns one 16-bit half of a RAM or ROM word. Each accepted access holds the processor clock for exactly one cycle through the `stall` output.

When no access is in progress, the control RAM is addressed by the next microaddress, which is the normal instruction-fetch path. The ROM is only ever addressed by the next microaddress, reduced modulo 1024. To read ROM location x, microcode must therefore place the instruction that follows the read strobe at location x mod 1024. Only one ROM bank is reachable. The memory arrays are outside the block: both have a synchronous read port and return data one clock after the address. If the processor clock is already held for another reason while an access is in progress, the result is unspecified, and the block raises `overlap` to flag it.

Address word layout: bits [15:6] carry the control-RAM word address. Bit 5 picks the half (1 = high 16 bits, 0 = low 16 bits). Bit 4 picks the read source (1 = ROM, 0 = RAM). Bits [3:0] are ignored.

Top module: `ctl_store_seq`

## Requirements
- R1: After synchronous reset, `stall`, `cram_we`, `rd_valid` and `overlap` are all 0.
- R2: A request (`rd_req` or `wr_req`) presented while `stall` is 0 is accepted. `stall` is then 1 in exactly the next cycle and 0 in the cycle after that.
- R3: For an accepted write, `cram_we` is 1 in the request cycle itself, with `cram_wdata` = {`wr_hi`, `wr_lo`}, so the word commits at the end of that cycle, before the stall cycle. `cram_we` is 0 during the stall cycle.
- R4: In the request cycle of an accepted access, `cram_addr` equals address-word bits [15:6]. In every other cycle it equals the low 10 bits of `next_upc`.
- R5: `rom_addr` equals `next_upc` modulo 1024 in every cycle.
- R6: For a read, address-word bit 4 selects the source (1 = ROM, 0 = RAM) and bit 5 selects the half (1 = bits [31:16], 0 = bits [15:0]). Bits [3:0] never affect the result. For a ROM read, bits [15:6] do not affect the result either.
- R7: For an accepted read, `rd_valid` is 1 for one cycle, the cycle after the stall cycle, and `rd_data` then holds the selected half. The word returned is the one the memory delivers for the address presented in the request cycle.
- R8: Requests presented while `stall` is 1 are ignored. They cause no write, no further stall cycle and no `rd_valid`.
- R9: When `rd_req` and `wr_req` are both 1 in an accepted cycle, the write is performed and the read is dropped: there is one stall cycle and no `rd_valid`.
- R10: `overlap` is 1 in a stall cycle if `ext_stall` was 1 in that access's request cycle or is 1 in the stall cycle itself. `overlap` is 0 in every cycle that is not a stall cycle.
- R11: A word written to RAM address a reads back unchanged, high half and low half, through RAM reads at address a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read strobe from the microinstruction |
| wr_req | input | 1 | Write strobe from the microinstruction |
| addr_word | input | 16 | Address word from the temporary register |
| wr_hi | input | 16 | High half of the write data |
| wr_lo | input | 16 | Low half of the write data |
| next_upc | input | 12 | Next microaddress |
| ext_stall | input | 1 | Clock already held for another reason |
| cram_addr | output | 10 | Control RAM address |
| cram_we | output | 1 | Control RAM write enable |
| cram_wdata | output | 32 | Control RAM write word |
| cram_rdata | input | 32 | Control RAM read word (one cycle after address) |
| rom_addr | output | 10 | Control ROM address |
| rom_rdata | input | 32 | Control ROM read word (one cycle after address) |
| stall | output | 1 | Holds the processor clock for one cycle |
| rd_data | output | 16 | Returned half-word |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| overlap | output | 1 | Access overlapped an external clock hold |

## Verification
On every cycle, the embedded assertions check the timing skeleton: one stall cycle per accepted request, a write enable that always precedes its stall cycle, `rd_valid` only directly after a stall cycle, and `overlap` raised after a request that met an external hold. Other behaviours only the bench scenarios can show, because they need a model of the memories' contents. These are: which address source feeds each port, which half and which source a read returns, that requests made during a stall leave the stored words untouched, the write-over-read priority, and the modulo-1024 ROM addressing over the wider microaddress range.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Kind of access accepted in the current cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Read selection taken from the address word
    typedef struct packed {
        logic from_rom;
        logic hi_half;
    } rd_sel_t;

    // Write has priority when both strobes are raised together
    function automatic acc_kind_e acc_of(input logic rd, input logic wr);
        if (wr)
            return ACC_WRITE;
        else if (rd)
            return ACC_READ;
        else
            return ACC_NONE;
    endfunction

endpackage

// File: rtl/csa_decode.sv
module csa_decode
    import csa_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RAM_AW   = 10,
    parameter int UPC_W    = 12,
    parameter int SRC_BIT  = 4,
    parameter int HALF_BIT = 5,
    parameter int RAM_LSB  = 6
) (
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              stall,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic [UPC_W-1:0]  next_upc,
    output acc_kind_e         kind,
    output rd_sel_t           sel,
    output logic [RAM_AW-1:0] ram_addr
);
    // Strobes are dead while the clock is held
    always_comb begin
        if (stall)
            kind = ACC_NONE;
        else
            kind = acc_of(rd_req, wr_req);
    end

    always_comb begin
        sel.from_rom = addr_word[SRC_BIT];
        sel.hi_half  = addr_word[HALF_BIT];
    end

    // Explicit address during the request cycle, fetch address otherwise
    always_comb begin
        if (kind != ACC_NONE)
            ram_addr = addr_word[RAM_LSB +: RAM_AW];
        else
            ram_addr = next_upc[RAM_AW-1:0];
    end

    logic unused_bits;
    assign unused_bits = ^{addr_word, next_upc};

endmodule

// File: rtl/csa_stall_ctl.sv
module csa_stall_ctl
    import csa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    input  rd_sel_t   sel,
    input  logic      ext_stall,
    output logic      stall,
    output logic      rd_pend,
    output rd_sel_t   sel_q,
    output logic      overlap
);
    logic ovl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall   <= 1'b0;
            rd_pend <= 1'b0;
            sel_q   <= '0;
            ovl_q   <= 1'b0;
        end else begin
            stall   <= (kind != ACC_NONE);
            rd_pend <= (kind == ACC_READ);
            ovl_q   <= (kind != ACC_NONE) && ext_stall;
            if (kind == ACC_READ)
                sel_q <= sel;
        end
    end

    assign overlap = stall & (ovl_q | ext_stall);

    // R2: the hold never lasts beyond one cycle
    assert_single_stall_R2: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R2: every accepted access produces a stall cycle
    assert_access_stalls_R2: assert property (@(posedge clk) disable iff (rst)
        (kind != ACC_NONE) |=> stall);

    // R10: an external hold at request time is reported in the stall cycle
    assert_overlap_flag_R10: assert property (@(posedge clk) disable iff (rst)
        ((kind != ACC_NONE) && ext_stall) |=> overlap);

endmodule

// File: rtl/csa_readback.sv
module csa_readback
    import csa_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_pend,
    input  rd_sel_t             sel_q,
    input  logic [2*HALF_W-1:0] cram_rdata,
    input  logic [2*HALF_W-1:0] rom_rdata,
    output logic [HALF_W-1:0]   rd_data,
    output logic                rd_valid
);
    logic [2*HALF_W-1:0] src_word;
    logic [HALF_W-1:0]   half_word;

    always_comb begin
        src_word  = sel_q.from_rom ? rom_rdata : cram_rdata;
        half_word = sel_q.hi_half ? src_word[2*HALF_W-1:HALF_W]
                                  : src_word[HALF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_pend;
            if (rd_pend)
                rd_data <= half_word;
        end
    end

    // R7: read data is a single-cycle pulse
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/ctl_store_seq.sv
module ctl_store_seq
    import csa_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int RAM_AW   = 10,
    parameter int ROM_AW   = 10,
    parameter int UPC_W    = 12,
    parameter int SRC_BIT  = 4,
    parameter int HALF_BIT = 5,
    parameter int RAM_LSB  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic [HALF_W-1:0]   addr_word,
    input  logic [HALF_W-1:0]   wr_hi,
    input  logic [HALF_W-1:0]   wr_lo,
    input  logic [UPC_W-1:0]    next_upc,
    input  logic                ext_stall,
    output logic [RAM_AW-1:0]   cram_addr,
    output logic                cram_we,
    output logic [2*HALF_W-1:0] cram_wdata,
    input  logic [2*HALF_W-1:0] cram_rdata,
    output logic [ROM_AW-1:0]   rom_addr,
    input  logic [2*HALF_W-1:0] rom_rdata,
    output logic                stall,
    output logic [HALF_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                overlap
);
    acc_kind_e kind;
    rd_sel_t   sel;
    rd_sel_t   sel_q;
    logic      rd_pend;

    csa_decode #(
        .ADDR_W(HALF_W), .RAM_AW(RAM_AW), .UPC_W(UPC_W),
        .SRC_BIT(SRC_BIT), .HALF_BIT(HALF_BIT), .RAM_LSB(RAM_LSB)
    ) u_dec (
        .rd_req(rd_req), .wr_req(wr_req), .stall(stall),
        .addr_word(addr_word), .next_upc(next_upc),
        .kind(kind), .sel(sel), .ram_addr(cram_addr)
    );

    csa_stall_ctl u_ctl (
        .clk(clk), .rst(rst), .kind(kind), .sel(sel),
        .ext_stall(ext_stall), .stall(stall), .rd_pend(rd_pend),
        .sel_q(sel_q), .overlap(overlap)
    );

    csa_readback #(.HALF_W(HALF_W)) u_rb (
        .clk(clk), .rst(rst), .rd_pend(rd_pend), .sel_q(sel_q),
        .cram_rdata(cram_rdata), .rom_rdata(rom_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Write commits in the request cycle, ahead of the hold
    assign cram_we    = (kind == ACC_WRITE);
    assign cram_wdata = {wr_hi, wr_lo};

    // ROM reachable only through the fetch address
    assign rom_addr = next_upc[ROM_AW-1:0];

    // R3: the write enable always precedes a stall cycle
    assert_write_before_stall_R3: assert property (@(posedge clk) disable iff (rst)
        cram_we |=> stall);

    // R7: read data appears only right after a stall cycle
    assert_valid_after_stall_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(stall));

endmodule

// File: tb/sim_ctl_store_seq.sv
`timescale 1ns/1ps
module sim_ctl_store_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_req, wr_req, ext_stall;
    logic [15:0] addr_word, wr_hi, wr_lo;
    logic [11:0] next_upc;
    logic [9:0]  cram_addr, rom_addr;
    logic        cram_we;
    logic [31:0] cram_wdata, cram_rdata, rom_rdata;
    logic        stall, rd_valid, overlap;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] ram [1024];
    logic [31:0] rom [1024];

    always #2.5 clk = ~clk;

    ctl_store_seq u0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
        .addr_word(addr_word), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .next_upc(next_upc), .ext_stall(ext_stall),
        .cram_addr(cram_addr), .cram_we(cram_we), .cram_wdata(cram_wdata),
        .cram_rdata(cram_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .stall(stall), .rd_data(rd_data), .rd_valid(rd_valid), .overlap(overlap)
    );

    // Synchronous-read memory models
    always @(posedge clk) begin
        if (cram_we) ram[cram_addr] <= cram_wdata;
        cram_rdata <= ram[cram_addr];
        rom_rdata  <= rom[rom_addr];
    end

    function automatic logic [31:0] rom_val(input int i);
        return {16'(i * 37 + 5), 16'(i) ^ 16'hA5A5};
    endfunction
    function automatic logic [15:0] hi_of(input int a);
        return 16'(a * 3 + 1);
    endfunction
    function automatic logic [15:0] lo_of(input int a);
        return ~16'(a * 11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_req = 0; wr_req = 0; ext_stall = 0;
    endtask

    task automatic do_write(input int a, input logic [11:0] upc);
        @(negedge clk);
        wr_req = 1; addr_word = 16'(a << 6) | 16'h000B;
        wr_hi = hi_of(a); wr_lo = lo_of(a); next_upc = upc;
        #1;
        chk("R3 we in request cycle", 32'(cram_we), 32'd1);
        chk("R3 write word", cram_wdata, {hi_of(a), lo_of(a)});
        chk("R4 explicit address", 32'(cram_addr), 32'(a));
        @(negedge clk);
        idle();
        #1;
        chk("R2 stall cycle", 32'(stall), 32'd1);
        chk("R3 no we in stall", 32'(cram_we), 32'd0);
        chk("R4 fetch address", 32'(cram_addr), 32'(upc[9:0]));
        @(negedge clk);
        #1;
        chk("R2 stall released", 32'(stall), 32'd0);
    endtask

    task automatic do_read(input logic [15:0] w, input logic [11:0] upc,
                           input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_req = 1; addr_word = w; next_upc = upc;
        #1;
        chk("R4 read address", 32'(cram_addr), 32'(w[15:6]));
        chk("R5 rom address", 32'(rom_addr), 32'(upc % 1024));
        @(negedge clk);
        idle();
        #1;
        chk("R2 read stall", 32'(stall), 32'd1);
        chk("R7 not valid in stall", 32'(rd_valid), 32'd0);
        @(negedge clk);
        #1;
        chk("R2 read stall released", 32'(stall), 32'd0);
        chk("R7 valid after stall", 32'(rd_valid), 32'd1);
        chk(req, 32'(rd_data), 32'(exp));
        @(negedge clk);
        #1;
        chk("R7 valid one cycle", 32'(rd_valid), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            rom[i] = rom_val(i);
            ram[i] = 32'h0;
        end
        rst = 1; idle();
        addr_word = 0; wr_hi = 0; wr_lo = 0; next_upc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 stall", 32'(stall), 32'd0);
        chk("R1 we", 32'(cram_we), 32'd0);
        chk("R1 valid", 32'(rd_valid), 32'd0);
        chk("R1 overlap", 32'(overlap), 32'd0);

        // R5: ROM address over the full microaddress range while idle
        for (int u = 0; u < 4096; u += 173) begin
            @(negedge clk);
            next_upc = 12'(u);
            #1;
            chk("R5 rom modulo", 32'(rom_addr), 32'(u % 1024));
            chk("R4 idle fetch", 32'(cram_addr), 32'(u % 1024));
        end

        // R11: write sweep then read back both halves
        for (int a = 0; a < 1024; a += 37) do_write(a, 12'(a * 5 + 7));
        do_write(1023, 12'hFFF);
        for (int a = 0; a < 1024; a += 37) begin
            do_read(16'(a << 6) | 16'h0020 | 16'(a % 16), 12'(a), hi_of(a), "R11 R6 ram high half");
            do_read(16'(a << 6) | 16'(a % 16), 12'(a + 9), lo_of(a), "R11 R6 ram low half");
        end
        do_read(16'hFFE0, 12'h3, hi_of(1023), "R11 top address high");

        // R6: ROM reads, address bits 15:6 and 3:0 are noise
        for (int u = 0; u < 4096; u += 211) begin
            do_read(16'(u * 64 + 16'h0030) | 16'(u % 16), 12'(u),
                    rom_val(u % 1024) >> 16, "R6 rom high half");
            do_read(16'(16'hFFC0 - u * 64) | 16'h0010, 12'(u),
                    16'(rom_val(u % 1024)), "R6 rom low half");
        end

        // R8: strobes during the stall cycle are ignored
        @(negedge clk);
        rd_req = 1; addr_word = 16'(74 << 6); next_upc = 12'd20;
        @(negedge clk);
        rd_req = 1; wr_req = 1; addr_word = 16'(111 << 6);
        wr_hi = 16'hDEAD; wr_lo = 16'hBEEF;
        #1;
        chk("R8 no we in stall", 32'(cram_we), 32'd0);
        @(negedge clk);
        idle();
        #1;
        chk("R8 no second stall", 32'(stall), 32'd0);
        chk("R7 first read data", 32'(rd_data), 32'(lo_of(74)));
        @(negedge clk);
        #1;
        chk("R8 no extra valid", 32'(rd_valid), 32'd0);
        do_read(16'(111 << 6) | 16'h0020, 12'd1, hi_of(111), "R8 word untouched");

        // R9: both strobes, write wins, read dropped
        @(negedge clk);
        rd_req = 1; wr_req = 1; addr_word = 16'(500 << 6) | 16'h0020;
        wr_hi = 16'h1234; wr_lo = 16'h5678;
        #1;
        chk("R9 write performed", 32'(cram_we), 32'd1);
        @(negedge clk);
        idle();
        #1;
        chk("R9 stall", 32'(stall), 32'd1);
        @(negedge clk);
        #1;
        chk("R9 read dropped", 32'(rd_valid), 32'd0);
        chk("R9 single stall", 32'(stall), 32'd0);
        do_read(16'(500 << 6), 12'd2, 16'h5678, "R9 written low");

        // R10: overlap cases
        @(negedge clk);
        ext_stall = 1;
        #1;
        chk("R10 no access no overlap", 32'(overlap), 32'd0);
        rd_req = 1; addr_word = 0;
        @(negedge clk);
        rd_req = 0; ext_stall = 0;
        #1;
        chk("R10 overlap from request cycle", 32'(overlap), 32'd1);
        @(negedge clk);
        #1;
        chk("R10 overlap cleared", 32'(overlap), 32'd0);
        wr_req = 1; addr_word = 16'(900 << 6);
        @(negedge clk);
        wr_req = 0; ext_stall = 1;
        #1;
        chk("R10 overlap in stall cycle", 32'(overlap), 32'd1);
        @(negedge clk);
        idle();
        #1;
        chk("R10 overlap after stall", 32'(overlap), 32'd0);
        wr_req = 1;
        @(negedge clk);
        idle();
        #1;
        chk("R10 clean access", 32'(overlap), 32'd0);
        @(negedge clk);

        // R1: reset mid-access clears everything
        rd_req = 1;
        @(negedge clk);
        idle(); rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 stall after reset", 32'(stall), 32'd0);
        chk("R1 valid after reset", 32'(rd_valid), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule